// File: doc/BRIEF.md
# Quasi-Resonant Valley Lockout Selector

This block decides at which valley of the drain-voltage ringing a quasi-resonant flyback controller may begin its next switching cycle. It watches the output-current setpoint code and the line-voltage sample code. From these two it locks a valley index through a hysteretic table with two axes. One axis is five setpoint bands. The other is a low/high line range, and high line adds one to the index.

After each off-time the block waits for the demagnetisation-end strobe. It then counts falling edges of the zero-crossing comparator output, and it raises a single-cycle turn-on request when the count reaches the locked index. If no valley arrives within a time-out window, a synthetic valley is counted instead. This lets the converter start up, and it keeps heavily damped ringing from stalling the cycle.

A foldback flag tells the downstream dead-time logic when the setpoint is too low for valley switching alone. A high-line flag reports the debounced line range. All thresholds are parameters: setpoint thresholds are in setpoint-code units, line thresholds are in line-code units, and the windows are in clock cycles.

Top module: `qr_valley_selector`

## Requirements
- R1: While reset is applied and in the cycle after it is released, `valley_idx` is 1 and `turn_on`, `foldback` and `high_line` are 0.
- R2: With the setpoint at full scale (1000), `valley_idx` is 1 at low line and 2 at high line. High line adds exactly one to the index of every setpoint band.
- R3: As the setpoint falls, the index advances by one each time the setpoint goes strictly below 800, 650, 500 and 350, in that order of bands.
- R4: As the setpoint rises, the index steps back by one each time the setpoint goes strictly above 900, 750, 600 and 450. A setpoint lying between the two thresholds of a band keeps the current index.
- R5: `foldback` sets when the setpoint goes strictly below 250. It clears only when the setpoint goes strictly above 350, and it holds its value in between.
- R6: `high_line` sets after `line_code` has stayed strictly above 264 for BLANK_CYC consecutive clocks. It clears after `line_code` has stayed strictly below 253 for BLANK_CYC consecutive clocks. A shorter excursion does not change it.
- R7: A valley is a high-to-low transition of `zcd_cmp`. After a `demag_end` strobe, the request fires in the cycle after the clock edge that sees the N-th valley, where N is `valley_idx`.
- R8: If TMO_CYC clocks pass after `demag_end`, or after the last counted valley, with no new valley, a synthetic valley is counted. The time-out restarts on every valley. Out of reset, counting is already armed, so the first request fires TMO_CYC clocks after release at low line.
- R9: `turn_on` is high for exactly one cycle per switching cycle. Valleys and time-outs that occur after a request and before the next `demag_end` are ignored.
- R10: `valley_idx` always lies between 1 and 6. It reaches 6 at high line in the lowest setpoint band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setpoint | input | SP_W | Output-current setpoint code; 1000 is full reference |
| line_code | input | LINE_W | Sampled line-voltage code |
| zcd_cmp | input | 1 | Zero-crossing comparator level; a falling edge marks a valley |
| demag_end | input | 1 | One-cycle strobe at the end of demagnetisation |
| turn_on | output | 1 | One-cycle request to start the next on-time |
| valley_idx | output | 3 | Locked valley index, 1 to 6 |
| foldback | output | 1 | Frequency-foldback mode required |
| high_line | output | 1 | Debounced high-line range |

## Verification
A wrong setpoint band, or a stale line-range flag, shows on `valley_idx` one clock after the setpoint or the blanking window settles. It also shifts the valley on which `turn_on` fires in the very next switching cycle. A valley counter or time-out counter that is out of step shows as a request fired one valley early or late, a request fired twice, or a time-out that lands a cycle away from TMO_CYC. Each of these is visible within one switching cycle. The bench therefore counts the `turn_on` pulses against numbered valleys, and it times the line flag and the time-out to the exact clock.

// File: rtl/vls_pkg.sv
`timescale 1ns/1ps
// Shared types for the valley lockout selector.
// Assumes: valley indices fit in three bits (1..6).
package vls_pkg;
    localparam int VIDX_W = 3;
    localparam int NBANDS = 5;

    typedef enum logic {
        CS_WAIT  = 1'b0,
        CS_COUNT = 1'b1
    } cnt_state_t;
endpackage

// File: rtl/vls_line_range.sv
`timescale 1ns/1ps
// Line-range detector. It raises high_line once the line code has stayed above
// HL_ON for BLANK_CYC clocks in a row, and drops it once the code has stayed
// below HL_OFF for the same time.
// Assumes: HL_OFF < HL_ON, and BLANK_CYC >= 1.
module vls_line_range #(
    parameter int LINE_W    = 9,
    parameter int HL_ON     = 264,
    parameter int HL_OFF    = 253,
    parameter int BLANK_CYC = 3125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_code,
    output logic              high_line
);
    localparam int BW = $clog2(BLANK_CYC + 1);
    localparam logic [LINE_W-1:0] ON_C  = LINE_W'(HL_ON);
    localparam logic [LINE_W-1:0] OFF_C = LINE_W'(HL_OFF);
    localparam logic [BW-1:0]     LAST  = BW'(BLANK_CYC - 1);

    logic          crossing;
    logic [BW-1:0] blank_cnt;

    // Does the present sample argue for the opposite range?
    always_comb begin
        crossing = high_line ? (line_code < OFF_C) : (line_code > ON_C);
    end

    // Blanking counter and range flag: flip only after a full run of crossings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_cnt <= '0;
            high_line <= 1'b0;
        end else if (!crossing) begin
            blank_cnt <= '0;
        end else if (blank_cnt == LAST) begin
            blank_cnt <= '0;
            high_line <= ~high_line;
        end else begin
            blank_cnt <= blank_cnt + 1'b1;
        end
    end

    // R6
    hl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(high_line) |-> ($past(line_code) > ON_C));
    // R6
    hl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(high_line) |-> ($past(line_code) < OFF_C));
endmodule

// File: rtl/vls_valley_table.sv
`timescale 1ns/1ps
// Setpoint axis of the valley table. It keeps a band register (0 = full load,
// 4 = lightest) that moves one step per clock, using separate falling and
// rising thresholds. It also keeps a hysteretic foldback flag.
// Assumes: UP_THR[i] > DN_THR[i], and FF_EXIT > FF_ENTER.
module vls_valley_table
    import vls_pkg::*;
#(
    parameter int SP_W             = 10,
    parameter int DN_THR [NBANDS-1] = '{800, 650, 500, 350},
    parameter int UP_THR [NBANDS-1] = '{900, 750, 600, 450},
    parameter int FF_ENTER         = 250,
    parameter int FF_EXIT          = 350
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SP_W-1:0] setpoint,
    output logic [2:0]      band,
    output logic            foldback
);
    localparam logic [SP_W-1:0] FF_IN_C  = SP_W'(FF_ENTER);
    localparam logic [SP_W-1:0] FF_OUT_C = SP_W'(FF_EXIT);
    localparam logic [2:0]      TOP_BAND = 3'(NBANDS - 1);

    logic [NBANDS-2:0] below_dn;
    logic [NBANDS-2:0] above_up;
    logic [2:0]        band_nxt;

    // One comparator pair per band boundary.
    for (genvar gi = 0; gi < NBANDS - 1; gi++) begin : g_thr
        assign below_dn[gi] = setpoint < SP_W'(DN_THR[gi]);
        assign above_up[gi] = setpoint > SP_W'(UP_THR[gi]);
    end

    // Next band: step down on the falling threshold, step up on the rising one.
    always_comb begin
        band_nxt = band;
        if (band < TOP_BAND && below_dn[band[1:0]]) begin
            band_nxt = band + 3'd1;
        end else if (band != 3'd0 && above_up[2'(band - 3'd1)]) begin
            band_nxt = band - 3'd1;
        end
    end

    // Band and foldback registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            band     <= 3'd0;
            foldback <= 1'b0;
        end else begin
            band <= band_nxt;
            if (setpoint < FF_IN_C) begin
                foldback <= 1'b1;
            end else if (setpoint > FF_OUT_C) begin
                foldback <= 1'b0;
            end
        end
    end

    // R3
    band_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (band != $past(band)) |-> (band == $past(band) + 3'd1 || band + 3'd1 == $past(band)));
    // R5
    ff_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(foldback) |-> ($past(setpoint) < FF_IN_C));
    // R5
    ff_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(foldback) |-> ($past(setpoint) > FF_OUT_C));
endmodule

// File: rtl/vls_valley_counter.sv
`timescale 1ns/1ps
// Valley counter. After demag_end it counts the falling edges of the
// zero-crossing comparator; a time-out with no valley counts as a valley.
// It requests turn-on at the target valley, then waits for the next demag_end.
// Assumes: target is 1..6, and TMO_CYC >= 2.
module vls_valley_counter
    import vls_pkg::*;
#(
    parameter int TMO_CYC = 812
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zcd_cmp,
    input  logic              demag_end,
    input  logic [VIDX_W-1:0] target,
    output logic              turn_on
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

    cnt_state_t        state;
    logic              zcd_prev;
    logic [TW-1:0]     tmo_cnt;
    logic [VIDX_W-1:0] vcnt;
    logic              valley_evt;
    logic              fire;

    // A valley is a comparator fall or an expired time-out while counting.
    always_comb begin
        valley_evt = (state == CS_COUNT) && ((zcd_prev && !zcd_cmp) || (tmo_cnt == TMO_LAST));
        fire       = valley_evt && ({1'b0, vcnt} + 4'd1 >= {1'b0, target});
    end

    // Comparator history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) zcd_prev <= 1'b0;
        else        zcd_prev <= zcd_cmp;
    end

    // Counting state machine, valley counter and time-out counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= CS_COUNT;
            vcnt    <= '0;
            tmo_cnt <= '0;
            turn_on <= 1'b0;
        end else begin
            turn_on <= fire;
            if (demag_end) begin
                state   <= CS_COUNT;
                vcnt    <= '0;
                tmo_cnt <= '0;
            end else if (fire) begin
                state   <= CS_WAIT;
                vcnt    <= '0;
                tmo_cnt <= '0;
            end else if (valley_evt) begin
                vcnt    <= vcnt + 1'b1;
                tmo_cnt <= '0;
            end else if (state == CS_COUNT) begin
                tmo_cnt <= tmo_cnt + 1'b1;
            end
        end
    end

    // R9
    ton_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on |=> !turn_on);
    // R9
    ton_from_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on |-> ($past(state) == CS_COUNT));
    // R8
    tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_cnt <= TMO_LAST);
endmodule

// File: rtl/qr_valley_selector.sv
`timescale 1ns/1ps
// Top level of the quasi-resonant valley lockout selector. It combines the
// setpoint band and the line range into a locked valley index, and it drives
// the valley counter that issues the turn-on requests.
// Assumes: synchronous active-low reset, and inputs already in the clock domain.
module qr_valley_selector
    import vls_pkg::*;
#(
    parameter int SP_W      = 10,
    parameter int LINE_W    = 9,
    parameter int HL_ON     = 264,
    parameter int HL_OFF    = 253,
    parameter int BLANK_CYC = 3125,
    parameter int TMO_CYC   = 812,
    parameter int FF_ENTER  = 250,
    parameter int FF_EXIT   = 350
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SP_W-1:0]   setpoint,
    input  logic [LINE_W-1:0] line_code,
    input  logic              zcd_cmp,
    input  logic              demag_end,
    output logic              turn_on,
    output logic [2:0]        valley_idx,
    output logic              foldback,
    output logic              high_line
);
    logic [2:0] band;

    vls_line_range #(
        .LINE_W(LINE_W), .HL_ON(HL_ON), .HL_OFF(HL_OFF), .BLANK_CYC(BLANK_CYC)
    ) u_line (
        .clk(clk), .rst_n(rst_n), .line_code(line_code), .high_line(high_line)
    );

    vls_valley_table #(
        .SP_W(SP_W), .FF_ENTER(FF_ENTER), .FF_EXIT(FF_EXIT)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .setpoint(setpoint), .band(band), .foldback(foldback)
    );

    // Locked index: band position plus one, plus one more at high line.
    always_comb begin
        valley_idx = band + 3'd1 + {2'b00, high_line};
    end

    vls_valley_counter #(
        .TMO_CYC(TMO_CYC)
    ) u_count (
        .clk(clk), .rst_n(rst_n), .zcd_cmp(zcd_cmp), .demag_end(demag_end),
        .target(valley_idx), .turn_on(turn_on)
    );

    // R10
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valley_idx >= 3'd1 && valley_idx <= 3'd6);
endmodule

// File: tb/qr_valley_selector_bench.sv
`timescale 1ns/1ps
// Directed bench for the valley lockout selector; one task per scenario.
module qr_valley_selector_bench;
    localparam int BLANK = 16;
    localparam int TMO   = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] setpoint = 10'd1000;
    logic [8:0] line_code = 9'd200;
    logic       zcd_cmp = 1'b0;
    logic       demag_end = 1'b0;
    logic       turn_on;
    logic [2:0] valley_idx;
    logic       foldback;
    logic       high_line;

    int n_chk = 0;
    int n_bad = 0;
    int ton_hits = 0;
    int ton_at = 0;
    int vnum = 0;
    int cyc = 0;

    qr_valley_selector #(
        .BLANK_CYC(BLANK), .TMO_CYC(TMO)
    ) u_qr_valley_selector (
        .clk(clk), .rst_n(rst_n), .setpoint(setpoint), .line_code(line_code),
        .zcd_cmp(zcd_cmp), .demag_end(demag_end), .turn_on(turn_on),
        .valley_idx(valley_idx), .foldback(foldback), .high_line(high_line)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (turn_on) begin
            ton_hits = ton_hits + 1;
            ton_at   = vnum;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_sp(input int v);
        setpoint = 10'(v);
        tick(6);
    endtask

    // R7/R9: numbered valleys after demag_end; count the requests.
    task automatic valley_cycle(input int exp_idx, input string req);
        ton_hits  = 0;
        ton_at    = 0;
        vnum      = 0;
        demag_end = 1'b1;
        tick(1);
        demag_end = 1'b0;
        for (int v = 1; v <= 6; v++) begin
            vnum    = v;
            zcd_cmp = 1'b1;
            tick(2);
            zcd_cmp = 1'b0;
            tick(2);
        end
        chk({req, " request valley"}, ton_at, exp_idx);
        chk("R9 single request per cycle", ton_hits, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        chk("R1 idx in reset", valley_idx, 1);
        chk("R1 ton in reset", turn_on, 0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 idx", valley_idx, 1);
        chk("R1 foldback", foldback, 0);
        chk("R1 high_line", high_line, 0);
        chk("R1 ton", turn_on, 0);
    endtask

    task automatic t_startup_timeout();
        // One edge has passed since release; the time-out fires at edge TMO.
        tick(TMO - 2);
        chk("R8 no early startup request", turn_on, 0);
        tick(1);
        chk("R8 startup request on time-out", turn_on, 1);
        tick(1);
        chk("R9 request one cycle", turn_on, 0);
        zcd_cmp = 1'b1;
        tick(2);
        zcd_cmp = 1'b0;
        tick(TMO + 5);
        chk("R9 valleys ignored while waiting", ton_hits, 1);
    endtask

    task automatic t_low_line_bands();
        set_sp(1000); chk("R2 full scale low line", valley_idx, 1);
        valley_cycle(1, "R7");
        set_sp(850);  chk("R4 hold between 800 and 900", valley_idx, 1);
        set_sp(790);  chk("R3 below 800", valley_idx, 2);
        set_sp(700);  chk("R4 hold band 2", valley_idx, 2);
        set_sp(640);  chk("R3 below 650", valley_idx, 3);
        valley_cycle(3, "R7");
        set_sp(490);  chk("R3 below 500", valley_idx, 4);
        set_sp(340);  chk("R3 below 350", valley_idx, 5);
        chk("R5 no foldback at 340", foldback, 0);
        set_sp(240);  chk("R5 foldback below 250", foldback, 1);
        set_sp(300);  chk("R5 foldback held at 300", foldback, 1);
        set_sp(350);  chk("R5 foldback held at 350", foldback, 1);
        set_sp(360);  chk("R5 foldback cleared above 350", foldback, 0);
        chk("R4 lowest band held at 360", valley_idx, 5);
        set_sp(460);  chk("R4 above 450", valley_idx, 4);
        set_sp(610);  chk("R4 above 600", valley_idx, 3);
        set_sp(760);  chk("R4 above 750", valley_idx, 2);
        set_sp(880);  chk("R4 hold below 900", valley_idx, 2);
        set_sp(910);  chk("R4 above 900", valley_idx, 1);
        set_sp(20);   chk("R3 multi-step fall", valley_idx, 5);
        set_sp(1000); chk("R4 multi-step rise", valley_idx, 1);
    endtask

    task automatic t_line_range();
        line_code = 9'd300;
        tick(10);
        line_code = 9'd260;
        tick(BLANK + 4);
        chk("R6 short excursion ignored", high_line, 0);
        line_code = 9'd300;
        tick(BLANK - 1);
        chk("R6 not set before blanking", high_line, 0);
        tick(1);
        chk("R6 set after blanking", high_line, 1);
        chk("R2 full scale high line", valley_idx, 2);
        valley_cycle(2, "R2");
        set_sp(340);
        chk("R10 high line lowest band", valley_idx, 6);
        valley_cycle(6, "R10");
        set_sp(1000);
        line_code = 9'd258;
        tick(BLANK + 4);
        chk("R6 held between thresholds", high_line, 1);
        line_code = 9'd250;
        tick(BLANK - 1);
        chk("R6 not cleared before blanking", high_line, 1);
        tick(1);
        chk("R6 cleared after blanking", high_line, 0);
        chk("R2 back to low line", valley_idx, 1);
    endtask

    task automatic t_timeout_restart();
        set_sp(790);
        chk("R3 index 2 for time-out test", valley_idx, 2);
        demag_end = 1'b1;
        tick(1);
        demag_end = 1'b0;
        tick(30);
        zcd_cmp = 1'b1;
        tick(1);
        zcd_cmp = 1'b0;
        tick(1);
        chk("R7 first valley no request", turn_on, 0);
        tick(TMO - 1);
        chk("R8 time-out restarted by valley", turn_on, 0);
        tick(1);
        chk("R8 time-out counted as second valley", turn_on, 1);
    endtask

    initial begin
        t_reset();
        t_startup_timeout();
        t_low_line_bands();
        t_line_range();
        t_timeout_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule